// File: doc/BRIEF.md
# Dual-Bank Interrupt Router

This block collects up to forty level-sensitive interrupt lines into two banks and sends each active source to one of two processor inputs. Each source has an enable bit and a steering bit. An enabled, pending source goes to the fast interrupt output when its steering bit is 1 and to the normal interrupt output when it is 0. Sources 0 to 31 occupy bank 0. Source n, for n of 32 or more, occupies bit n−32 of bank 1. No pending state is held beyond one clock. Each pending bit is a registered copy of its input line, so it clears as soon as the line drops.

The block also raises a wake request for a halted processor. While the halt input is high, any pending source that is enabled wakes the core. When the idle mask is set to all ones, masked pending sources wake the core as well. A 32-bit register port gives software access to the enable and steering registers, the idle control, a forty-entry priority table and three pending views. The three views are raw, routed-fast and routed-normal. A separate block works out the winning priority, so its register slot reads as zero here.

Reads and writes both act on the rising clock edge. Write data takes effect at that edge. Read data appears on the port one cycle after the read strobe, and it holds until the next read.

Top module: `intr_router_core`

## Requirements
- R1: Each pending bit holds the level its input line had at the previous rising edge. It is 1 when the line was high and 0 when it was low. Source n with n ≥ 32 appears at bit n−32 of bank 1. Raw pending reads at 0x10 (bank 0) and 0xAC (bank 1) return these bits unmasked.
- R2: `fast_irq` is high exactly when some source in either bank has its pending, enable and steering bits all equal to 1.
- R3: `norm_irq` is high exactly when some source in either bank is pending and enabled and has a steering bit of 0.
- R4: `wake_req` is the combinational AND of `cpu_halted` with this condition: some source in either bank is pending AND (enabled OR idle mask). It is low whenever `cpu_halted` is low.
- R5: A write to 0x14 with data bit 0 = 1 clears the idle mask to all zeros. A write with bit 0 = 0 sets the idle mask to all ones. A read of 0x14 returns 1 while the idle mask is zero and 0 otherwise. After reset the idle mask is zero.
- R6: The enable registers (0x04 bank 0, 0xA0 bank 1) and the steering registers (0x08 bank 0, 0xA4 bank 1) read back what was written. Bank 1 bits 31:8 always read 0.
- R7: The routed-normal read (0x00 bank 0, 0x9C bank 1) returns pending AND enabled AND NOT steering. The routed-fast read (0x0C bank 0, 0xA8 bank 1) returns pending AND enabled AND steering.
- R8: Priority entry i sits at 0x1C+4·i for i < 32 and at 0xB0+4·(i−32) for i from 32 to 39. A write keeps only data bits 31 and 5:0, and every other bit reads 0.
- R9: The six pending registers are read-only. Writes to them change nothing that a later read shows.
- R10: A read of an unmapped offset returns 0. This covers 0x18, any offset above 0xCC and any offset that is not a multiple of 4. A write to an unmapped offset changes no register.
- R11: Reset clears enable, steering, pending and every priority entry. All three outputs are low after reset.
- R12: Read data appears on `bus_rdata` one cycle after `bus_rd`. It reflects the state before that edge, so a read and a write to the same register in the same cycle return the old value. `bus_rdata` holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level | input | NUM_SRC (40) | Interrupt source levels, already synchronous to clk |
| cpu_halted | input | 1 | High while the processor is halted |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| fast_irq | output | 1 | Fast interrupt request |
| norm_irq | output | 1 | Normal interrupt request |
| wake_req | output | 1 | Wake request for a halted processor |

## Verification
The assertions assume that `src_level` and the bus strobes are synchronous to `clk` and never unknown. They also assume that `bus_addr` and `bus_wdata` are stable for the whole cycle in which a strobe is high. The bench meets these conditions by changing every input on the falling edge only and by holding the address and data for exactly one full cycle per access. It never leaves a strobe floating. The halt input is also changed off the rising edge, so the combinational wake path is sampled after it has settled and not at a clock edge.

// File: rtl/intr_router_pkg.sv
package intr_router_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int BANK_W      = 32;
    localparam int PRIO_IDX_W  = 6;
    localparam int PRIO_CODE_W = 6;
    localparam int PRIO_FLAG_B = 31;

    // Register offsets; the bank-1 group mirrors bank 0 at a fixed distance.
    localparam logic [ADDR_W-1:0] OFS_NPEND0   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK0    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STEER0   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_FPEND0   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_RPEND0   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_IDLE     = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PRIO_LO  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_PRIO_LE  = 8'h98;
    localparam logic [ADDR_W-1:0] OFS_NPEND1   = 8'h9C;
    localparam logic [ADDR_W-1:0] OFS_MASK1    = 8'hA0;
    localparam logic [ADDR_W-1:0] OFS_STEER1   = 8'hA4;
    localparam logic [ADDR_W-1:0] OFS_FPEND1   = 8'hA8;
    localparam logic [ADDR_W-1:0] OFS_RPEND1   = 8'hAC;
    localparam logic [ADDR_W-1:0] OFS_PRIO_HI  = 8'hB0;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_NPEND,
        RK_MASK,
        RK_STEER,
        RK_FPEND,
        RK_RPEND,
        RK_IDLE,
        RK_PRIO
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e               kind;
        logic                    bank;
        logic [PRIO_IDX_W-1:0]   prio_idx;
    } reg_sel_t;

    // Map a byte offset onto a register kind, bank and priority index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int num_src);
        reg_sel_t              s;
        logic [ADDR_W-1:0]     d_lo;
        logic [ADDR_W-1:0]     d_hi;
        logic [PRIO_IDX_W-1:0] i_lo;
        logic [PRIO_IDX_W-1:0] i_hi;
        s.kind     = RK_NONE;
        s.bank     = 1'b0;
        s.prio_idx = '0;
        d_lo = a - OFS_PRIO_LO;
        d_hi = a - OFS_PRIO_HI;
        i_lo = PRIO_IDX_W'(d_lo >> 2);
        i_hi = PRIO_IDX_W'(d_hi >> 2);
        if (a[1:0] == 2'b00) begin
            case (a)
                OFS_NPEND0: s.kind = RK_NPEND;
                OFS_MASK0:  s.kind = RK_MASK;
                OFS_STEER0: s.kind = RK_STEER;
                OFS_FPEND0: s.kind = RK_FPEND;
                OFS_RPEND0: s.kind = RK_RPEND;
                OFS_IDLE:   s.kind = RK_IDLE;
                OFS_NPEND1: begin s.kind = RK_NPEND; s.bank = 1'b1; end
                OFS_MASK1:  begin s.kind = RK_MASK;  s.bank = 1'b1; end
                OFS_STEER1: begin s.kind = RK_STEER; s.bank = 1'b1; end
                OFS_FPEND1: begin s.kind = RK_FPEND; s.bank = 1'b1; end
                OFS_RPEND1: begin s.kind = RK_RPEND; s.bank = 1'b1; end
                default: begin
                    if (a >= OFS_PRIO_LO && a <= OFS_PRIO_LE) begin
                        s.kind     = RK_PRIO;
                        s.prio_idx = i_lo;
                    end else if (a >= OFS_PRIO_HI &&
                                 int'(i_hi) < num_src - BANK_W) begin
                        s.kind     = RK_PRIO;
                        s.prio_idx = PRIO_IDX_W'(BANK_W) + i_hi;
                    end
                end
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/intr_bank.sv
module intr_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    input  logic         mask_we,
    input  logic         steer_we,
    input  logic [W-1:0] wdata_i,
    input  logic         idle_all_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] steer_o,
    output logic         fast_hit_o,
    output logic         norm_hit_o,
    output logic         wake_hit_o
);

    logic [W-1:0] pend_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] steer_q;
    logic [W-1:0] live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            mask_q  <= '0;
            steer_q <= '0;
        end else begin
            pend_q <= level_i;
            if (mask_we)  mask_q  <= wdata_i;
            if (steer_we) steer_q <= wdata_i;
        end
    end

    always_comb begin
        live       = pend_q & mask_q;
        fast_hit_o = |(live & steer_q);
        norm_hit_o = |(live & ~steer_q);
        wake_hit_o = |(pend_q & (mask_q | {W{idle_all_i}}));
    end

    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign steer_o = steer_q;

    // R1
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(level_i));

    // R6
    mask_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> mask_q == $past(wdata_i));

    // R6
    steer_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        steer_we |=> steer_q == $past(wdata_i));

endmodule

// File: rtl/intr_prio_table.sv
module intr_prio_table
    import intr_router_pkg::*;
#(
    parameter int N = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [PRIO_IDX_W-1:0] idx,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata
);

    logic [N-1:0]        flag_q;
    logic [PRIO_CODE_W-1:0] code_q [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
                code_q[i] <= '0;
            end else if (we && int'(idx) == i) begin
                flag_q[i] <= wdata[PRIO_FLAG_B];
                code_q[i] <= wdata[PRIO_CODE_W-1:0];
            end
        end

        // R8
        prio_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && int'(idx) == i) |=>
                (flag_q[i] == $past(wdata[PRIO_FLAG_B]) &&
                 code_q[i] == $past(wdata[PRIO_CODE_W-1:0])));
    end

    always_comb begin
        rdata = '0;
        if (int'(idx) < N) begin
            rdata[PRIO_FLAG_B]       = flag_q[idx];
            rdata[PRIO_CODE_W-1:0]   = code_q[idx];
        end
    end

endmodule

// File: rtl/intr_router_core.sv
module intr_router_core
    import intr_router_pkg::*;
#(
    parameter int NUM_SRC = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               cpu_halted,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               fast_irq,
    output logic               norm_irq,
    output logic               wake_req
);

    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;

    reg_sel_t              sel;
    logic                  idle_all_q;
    logic [DATA_W-1:0]     rd_next;
    logic [DATA_W-1:0]     prio_rdata;
    logic [DATA_W-1:0]     pend_w  [NUM_BANKS];
    logic [DATA_W-1:0]     mask_w  [NUM_BANKS];
    logic [DATA_W-1:0]     steer_w [NUM_BANKS];
    logic [NUM_BANKS-1:0]  fast_hit;
    logic [NUM_BANKS-1:0]  norm_hit;
    logic [NUM_BANKS-1:0]  wake_hit;
    logic [DATA_W-1:0]     cur_pend;
    logic [DATA_W-1:0]     cur_mask;
    logic [DATA_W-1:0]     cur_steer;

    assign sel = decode_addr(bus_addr, NUM_SRC);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO = b * BANK_W;
        localparam int W  = (NUM_SRC - LO < BANK_W) ? (NUM_SRC - LO) : BANK_W;

        logic [W-1:0] pend_b;
        logic [W-1:0] mask_b;
        logic [W-1:0] steer_b;
        logic         mask_we;
        logic         steer_we;

        assign mask_we  = bus_wr && sel.kind == RK_MASK  && int'(sel.bank) == b;
        assign steer_we = bus_wr && sel.kind == RK_STEER && int'(sel.bank) == b;

        intr_bank #(.W(W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .level_i    (src_level[LO+W-1:LO]),
            .mask_we    (mask_we),
            .steer_we   (steer_we),
            .wdata_i    (bus_wdata[W-1:0]),
            .idle_all_i (idle_all_q),
            .pend_o     (pend_b),
            .mask_o     (mask_b),
            .steer_o    (steer_b),
            .fast_hit_o (fast_hit[b]),
            .norm_hit_o (norm_hit[b]),
            .wake_hit_o (wake_hit[b])
        );

        assign pend_w[b]  = DATA_W'(pend_b);
        assign mask_w[b]  = DATA_W'(mask_b);
        assign steer_w[b] = DATA_W'(steer_b);
    end

    intr_prio_table #(.N(NUM_SRC)) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_wr && sel.kind == RK_PRIO),
        .idx   (sel.prio_idx),
        .wdata (bus_wdata),
        .rdata (prio_rdata)
    );

    // Idle control: bit 0 = 1 selects "enabled only", 0 selects "any pending".
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_all_q <= 1'b0;
        end else if (bus_wr && sel.kind == RK_IDLE) begin
            idle_all_q <= ~bus_wdata[0];
        end
    end

    always_comb begin
        cur_pend  = pend_w[sel.bank];
        cur_mask  = mask_w[sel.bank];
        cur_steer = steer_w[sel.bank];
        rd_next   = '0;
        unique case (sel.kind)
            RK_NONE:  rd_next = '0;
            RK_NPEND: rd_next = cur_pend & cur_mask & ~cur_steer;
            RK_MASK:  rd_next = cur_mask;
            RK_STEER: rd_next = cur_steer;
            RK_FPEND: rd_next = cur_pend & cur_mask & cur_steer;
            RK_RPEND: rd_next = cur_pend;
            RK_IDLE:  rd_next = DATA_W'(!idle_all_q);
            RK_PRIO:  rd_next = prio_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

    assign fast_irq = |fast_hit;
    assign norm_irq = |norm_hit;
    assign wake_req = cpu_halted && (|wake_hit);

    // R4
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_halted |-> !wake_req);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel.kind == RK_NONE) |=> bus_rdata == '0);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5
    idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.kind == RK_IDLE) |=> idle_all_q == !$past(bus_wdata[0]));

endmodule

// File: tb/tb_intr_router_core.sv
module tb_intr_router_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_level = '0;
    logic        cpu_halted = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        fast_irq;
    logic        norm_irq;
    logic        wake_req;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        resp_due = 1'b0;

    // Bench-side model of the registers the requirements describe.
    logic [31:0] m_mask0 = '0, m_mask1 = '0, m_steer0 = '0, m_steer1 = '0;
    logic        m_idle_all = 1'b0;

    always #5 clk = ~clk;

    intr_router_core dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level), .cpu_halted(cpu_halted),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fast_irq(fast_irq), .norm_irq(norm_irq),
        .wake_req(wake_req)
    );

    function automatic logic [31:0] pend0(); return src_level[31:0]; endfunction
    function automatic logic [31:0] pend1(); return {24'h0, src_level[39:32]}; endfunction

    function automatic logic exp_fast();
        return |(pend0() & m_mask0 & m_steer0) | |(pend1() & m_mask1 & m_steer1);
    endfunction
    function automatic logic exp_norm();
        return |(pend0() & m_mask0 & ~m_steer0) | |(pend1() & m_mask1 & ~m_steer1);
    endfunction
    function automatic logic exp_wake();
        return cpu_halted && (|(pend0() & (m_mask0 | {32{m_idle_all}})) ||
                              |(pend1() & (m_mask1 | {32{m_idle_all}})));
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag);
        check(32'(fast_irq), 32'(exp_fast()), {tag, " fast_irq"});
        check(32'(norm_irq), 32'(exp_norm()), {tag, " norm_irq"});
        check(32'(wake_req), 32'(exp_wake()), {tag, " wake_req"});
    endtask

    function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h04: m_mask0  = d;
            8'hA0: m_mask1  = d & 32'hFF;
            8'h08: m_steer0 = d;
            8'hA4: m_steer1 = d & 32'hFF;
            8'h14: m_idle_all = ~d[0];
            default: ;
        endcase
    endfunction

    // Driver: called at a falling edge, returns at the next falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rdwr(input logic [7:0] a, input logic [31:0] d,
                        input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        model_write(a, d);
    endtask

    // Monitor: compares each read response in the cycle after its strobe.
    always @(posedge clk) resp_due <= bus_rd;

    always @(negedge clk) begin
        if (resp_due) begin
            if (exp_q.size() == 0) begin
                check(bus_rdata, 32'hDEAD_BEEF, "R12 unexpected read response");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata, e, t);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        check_outs("R11 after reset");
        rd(8'h04, 32'h0, "R11 mask0 reset");
        rd(8'hA4, 32'h0, "R11 steer1 reset");
        rd(8'h10, 32'h0, "R11 raw pend0 reset");
        rd(8'h30, 32'h0, "R11 prio entry 5 reset");
        rd(8'h14, 32'h1, "R5 idle read after reset");

        // R2 R3 bank 0 routing
        wr(8'h04, 32'hFFFF_0003);
        wr(8'h08, 32'h0000_0001);
        src_level[0] = 1'b1;
        @(negedge clk);
        check_outs("R2 fast from source 0");
        src_level[1] = 1'b1;
        @(negedge clk);
        check_outs("R3 normal from source 1");
        rd(8'h00, 32'h0000_0002, "R7 normal pending bank0");
        rd(8'h0C, 32'h0000_0001, "R7 fast pending bank0");
        src_level[4] = 1'b1;
        @(negedge clk);
        rd(8'h10, 32'h0000_0013, "R1 raw pending bank0 includes masked");
        check_outs("R3 masked source 4 adds nothing");

        // R1 pending follows level with no latching
        src_level[1:0] = 2'b00; src_level[4] = 1'b0;
        src_level[35] = 1'b1;
        @(negedge clk);
        check_outs("R1 pending cleared with input");
        rd(8'hAC, 32'h0000_0008, "R1 source 35 at bank1 bit 3");
        wr(8'hA0, 32'hFFFF_FFFF);
        rd(8'hA0, 32'h0000_00FF, "R6 bank1 enable upper bits zero");
        check_outs("R3 bank1 normal");
        wr(8'hA4, 32'h0000_0008);
        check_outs("R2 bank1 fast");
        rd(8'hA8, 32'h0000_0008, "R7 fast pending bank1");
        rd(8'h9C, 32'h0000_0000, "R7 normal pending bank1");
        rd(8'h08, 32'h0000_0001, "R6 steer0 readback");

        // R4 R5 wake
        wr(8'hA0, 32'h0);
        #1;
        check_outs("R4 not halted no wake");
        cpu_halted = 1'b1;
        #1;
        check_outs("R4 halted masked source no wake");
        @(negedge clk);
        wr(8'h14, 32'h0);
        check_outs("R5 idle all-ones wakes on masked source");
        rd(8'h14, 32'h0, "R5 idle read when all ones");
        wr(8'h14, 32'h1);
        check_outs("R5 idle zero stops wake");
        rd(8'h14, 32'h1, "R5 idle read when zero");
        wr(8'hA0, 32'h0000_0008);
        check_outs("R4 enabled pending wakes");
        cpu_halted = 1'b0;
        #1;
        check_outs("R4 wake drops with halt");
        @(negedge clk);

        // R8 priority table
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, 32'h8000_003F, "R8 entry 0 keeps bits 31 and 5:0");
        wr(8'h98, 32'h1234_5678);
        rd(8'h98, 32'h0000_0038, "R8 entry 31");
        wr(8'hB0, 32'h8000_0025);
        rd(8'hB0, 32'h8000_0025, "R8 entry 32");
        wr(8'hCC, 32'h7FFF_FFC0);
        rd(8'hCC, 32'h0000_0000, "R8 entry 39 drops middle bits");
        rd(8'h1C, 32'h8000_003F, "R8 entry 0 untouched by others");

        // R9 pending registers read-only
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'hAC, 32'h0);
        rd(8'h10, 32'h0, "R9 raw pend0 unchanged by write");
        rd(8'h00, 32'h0, "R9 normal pend0 unchanged by write");
        rd(8'hAC, 32'h0000_0008, "R9 raw pend1 unchanged by write");
        check_outs("R9 outputs unchanged");

        // R10 unmapped
        rd(8'h18, 32'h0, "R10 priority-result slot reads zero");
        rd(8'hD0, 32'h0, "R10 offset above map");
        rd(8'h05, 32'h0, "R10 misaligned offset");
        wr(8'hD0, 32'hFFFF_FFFF);
        wr(8'h06, 32'hFFFF_FFFF);
        rd(8'h04, 32'hFFFF_0003, "R10 mask0 unchanged by unmapped write");
        rd(8'h08, 32'h0000_0001, "R10 steer0 unchanged by unmapped write");

        // R12 read and write in the same cycle
        rdwr(8'h04, 32'h0000_00F0, 32'hFFFF_0003, "R12 same-cycle read sees old");
        @(negedge clk);
        check(bus_rdata, 32'hFFFF_0003, "R12 rdata holds without read");
        rd(8'h04, 32'h0000_00F0, "R12 new value next read");

        repeat (2) @(negedge clk);
        check(32'(exp_q.size()), 32'h0, "R12 all reads answered");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule